// File: doc/BRIEF.md
# Prioritised Instruction Fetch Request Controller

This block sits between the instruction buffer queue and a fixed-latency instruction cache in a decoupled fetch-execute front end. Every cycle it gathers the fetch requests that may arise and picks at most one to send to the cache. There are five kinds of request: a sequential refill, a predicted-branch target from a prepare-to-branch operation, a mispredict recovery of either kind, and an exception or reset vector. While the cache is not ready, only the strongest pending redirect is kept in a single next-fetch register. A sequential refill is never stored there. It is worked out again each cycle from the buffer space.

A shift-style table follows each fetch for the LAT cycles it spends inside the cache. Each entry holds the fetch's line address, a valid bit and an on-path bit. A flush, or the invalidate mask from the pairing tracker, clears the valid bit, so data that comes back for a cancelled fetch is dropped. A small queue holds the fall-through address (line plus package offset) of every decoded paired branch. A branch that was predicted taken but falls through takes its recovery address from the head of that queue.

Top module: `fetch_ctl`

## Requirements
- R1: After reset the table holds no fetch and `rsp_keep` is low. Reset also loads the next-fetch register with an exception-rank request to `RESET_VEC`, so the first cycle with `cache_ready` high issues `RESET_VEC`.
- R2: `req_valid` is high only in cycles where `cache_ready` is high, and at most one request goes out per cycle. A redirect that arrives while the cache is not ready is held and issued in the first ready cycle.
- R3: Among requests that arrive in the same cycle, an exception has the highest rank. A mispredict (`mp_valid`, with either value of `mp_pred_taken`) comes next, then a PBR target (`pbr_req`), and a sequential refill is the lowest.
- R4: The next-fetch register stores its rank as three flags: bit 0 for PBR, bit 1 for mispredict, bit 2 for exception. At most one flag is set, and all flags clear means no redirect is held. A new redirect whose rank is equal to or higher than the held one replaces it. A redirect with a lower rank is dropped.
- R5: A sequential refill is issued only when no redirect is held or arriving, the cache is ready, and `buf_free` is strictly greater than the number of table entries that are both busy and valid in that cycle.
- R6: Every issued request moves the sequential pointer to its own line address plus 32, so a redirect also sets the line that later refills continue from.
- R7: An issued fetch enters slot 0 with busy=1, valid=1, on-path=0 and its address, and moves up one slot each cycle. Slot LAT-1 is the one returning from the cache, and its address is shown on `rsp_addr`.
- R8: A mispredict or exception clears the valid bit of every outstanding fetch. This includes the fetch returning in that same cycle, whose `rsp_keep` is forced low.
- R9: Setting bit i of `inv_mask` clears the valid bit of slot i, which applies to the returning slot in that cycle. Setting bit i of `onpath_set` sets the on-path bit of the entry in slot i as it moves on.
- R10: The sequential-target queue pushes {`pbd_addr` line, `pbd_ofs`} on `pbd_valid` and pops on `pb_retire`. A mispredict with `mp_pred_taken`=1 fetches the head line and drives the head offset on `req_ofs`. Any mispredict or exception empties the queue and ignores a push or pop in that same cycle.
- R11: Every request address is aligned to a 32-byte line (low 5 bits zero). `req_ofs` is zero except on a taken-prediction recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_ready | input | 1 | Cache can accept a request this cycle |
| buf_free | input | FREE_W | Number of empty instruction buffers |
| pbr_req | input | 1 | PBR predicted-target fetch request |
| pbr_tgt | input | ADDR_W | PBR predicted target address |
| mp_valid | input | 1 | Branch mispredict |
| mp_pred_taken | input | 1 | 1: predicted taken, recover to queue head; 0: recover to `mp_tgt` |
| mp_tgt | input | ADDR_W | Actual target of a not-taken-predicted branch |
| exc_req | input | 1 | Exception request |
| exc_vec | input | ADDR_W | Exception handler address |
| inv_mask | input | LAT | Per-slot invalidate from the pairing tracker |
| onpath_set | input | LAT | Per-slot on-path set from the pairing tracker |
| pbd_valid | input | 1 | Paired branch decoded |
| pbd_addr | input | ADDR_W | Fall-through line address after that branch |
| pbd_ofs | input | OFS_W | Package offset within the fall-through line |
| pb_retire | input | 1 | Oldest paired branch resolved as predicted |
| req_valid | output | 1 | Fetch request to cache |
| req_addr | output | ADDR_W | Line address of the fetch |
| req_ofs | output | OFS_W | Package offset for the fetch |
| rsp_keep | output | 1 | Data returning this cycle is valid |
| rsp_addr | output | ADDR_W | Address tag of the returning fetch |
| ot_busy | output | LAT | Slot occupancy, slot 0 newest |
| ot_valid | output | LAT | Slot valid bits |
| ot_onpath | output | LAT | Slot on-path bits |
| ot_addr | output | LAT*ADDR_W | Slot address tags, slot i at bits [i*ADDR_W +: ADDR_W] |

## Verification
The most delicate overlaps happen when a redirect that changes the pointer lands in the same cycle as a flush of fetches already in flight. Examples are a mispredict that hits a fetch returning that very cycle, or a taken-prediction recovery that pops the queue while a new paired-branch decode tries to push into it. Directed sequences set up both of these deliberately, and they also stack several redirects of different rank while the cache is held busy. A long pseudo-random phase then lets held requests, refills, masks and queue traffic collide freely. On every clock, a behavioural model made of counters and queues predicts the request, the response keep and every table slot, and all of them are compared against the design.

// File: rtl/fetch_ctl_pkg.sv
`timescale 1ns/1ps
package fetch_ctl_pkg;

   typedef enum logic [1:0] {
      RK_SEQ = 2'd0,
      RK_PBR = 2'd1,
      RK_MP  = 2'd2,
      RK_EXC = 2'd3
   } fc_rank_e;

   localparam int FC_FLAG_W = 3;

   // flags: bit0 PBR, bit1 mispredict, bit2 exception; zero = none held
   function automatic fc_rank_e rank_of(input logic [FC_FLAG_W-1:0] f);
      if (f[2]) return RK_EXC;
      if (f[1]) return RK_MP;
      if (f[0]) return RK_PBR;
      return RK_SEQ;
   endfunction

   function automatic logic [FC_FLAG_W-1:0] flags_of(input fc_rank_e r);
      case (r)
         RK_EXC:  return 3'b100;
         RK_MP:   return 3'b010;
         RK_PBR:  return 3'b001;
         default: return 3'b000;
      endcase
   endfunction

endpackage

// File: rtl/fc_arbiter.sv
`timescale 1ns/1ps
module fc_arbiter
   import fetch_ctl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 3
) (
   input  logic              cache_ready,
   input  fc_rank_e          held_rank,
   input  logic [ADDR_W-1:0] held_addr,
   input  logic [OFS_W-1:0]  held_ofs,
   input  logic              exc_req,
   input  logic [ADDR_W-1:0] exc_addr,
   input  logic              mp_valid,
   input  logic              mp_pred_taken,
   input  logic [ADDR_W-1:0] mp_addr,
   input  logic [ADDR_W-1:0] rec_addr,
   input  logic [OFS_W-1:0]  rec_ofs,
   input  logic              pbr_req,
   input  logic [ADDR_W-1:0] pbr_addr,
   input  logic              seq_room,
   input  logic [ADDR_W-1:0] seq_addr,
   output logic              issue,
   output logic [ADDR_W-1:0] iss_addr,
   output logic [OFS_W-1:0]  iss_ofs,
   output fc_rank_e          nxt_rank,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic [OFS_W-1:0]  nxt_ofs
);

   fc_rank_e          in_rank, win_rank;
   logic [ADDR_W-1:0] in_addr, win_addr;
   logic [OFS_W-1:0]  in_ofs, win_ofs;

   // strongest request arriving this cycle
   always_comb begin
      in_rank = RK_SEQ;
      in_addr = '0;
      in_ofs  = '0;
      if (exc_req) begin
         in_rank = RK_EXC;
         in_addr = exc_addr;
      end else if (mp_valid) begin
         in_rank = RK_MP;
         if (mp_pred_taken) begin
            in_addr = rec_addr;
            in_ofs  = rec_ofs;
         end else begin
            in_addr = mp_addr;
         end
      end else if (pbr_req) begin
         in_rank = RK_PBR;
         in_addr = pbr_addr;
      end
   end

   // newest wins on equal rank, held wins only when strictly stronger
   always_comb begin
      if (in_rank != RK_SEQ && in_rank >= held_rank) begin
         win_rank = in_rank;
         win_addr = in_addr;
         win_ofs  = in_ofs;
      end else begin
         win_rank = held_rank;
         win_addr = held_addr;
         win_ofs  = held_ofs;
      end
   end

   always_comb begin
      issue    = 1'b0;
      iss_addr = seq_addr;
      iss_ofs  = '0;
      nxt_rank = win_rank;
      nxt_addr = win_addr;
      nxt_ofs  = win_ofs;
      if (win_rank != RK_SEQ) begin
         if (cache_ready) begin
            issue    = 1'b1;
            iss_addr = win_addr;
            iss_ofs  = win_ofs;
            nxt_rank = RK_SEQ;
         end
      end else if (cache_ready && seq_room) begin
         issue = 1'b1;
      end
   end

endmodule

// File: rtl/fc_otable.sv
`timescale 1ns/1ps
module fc_otable #(
   parameter int ADDR_W = 32,
   parameter int LAT    = 2,
   localparam int CNT_W = $clog2(LAT + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       issue,
   input  logic [ADDR_W-1:0]          iss_addr,
   input  logic                       flush,
   input  logic [LAT-1:0]             inv_mask,
   input  logic [LAT-1:0]             onpath_set,
   output logic [LAT-1:0]             busy,
   output logic [LAT-1:0]             valid,
   output logic [LAT-1:0]             onpath,
   output logic [LAT-1:0][ADDR_W-1:0] addr,
   output logic                       ret_keep,
   output logic [ADDR_W-1:0]          ret_addr,
   output logic [CNT_W-1:0]           live_cnt
);

   logic [LAT-1:0]             busy_q, valid_q, onpath_q;
   logic [LAT-1:0][ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= '0;
         valid_q  <= '0;
         onpath_q <= '0;
         addr_q   <= '0;
      end else begin
         busy_q[0]   <= issue;
         valid_q[0]  <= issue;
         onpath_q[0] <= 1'b0;
         if (issue) addr_q[0] <= iss_addr;
         for (int i = 1; i < LAT; i++) begin
            busy_q[i]   <= busy_q[i-1];
            valid_q[i]  <= valid_q[i-1] & ~(flush | inv_mask[i-1]);
            onpath_q[i] <= onpath_q[i-1] | onpath_set[i-1];
            addr_q[i]   <= addr_q[i-1];
         end
      end
   end

   always_comb begin
      live_cnt = '0;
      for (int i = 0; i < LAT; i++)
         live_cnt = live_cnt + CNT_W'(busy_q[i] & valid_q[i]);
   end

   assign busy     = busy_q;
   assign valid    = valid_q;
   assign onpath   = onpath_q;
   assign addr     = addr_q;
   assign ret_keep = busy_q[LAT-1] & valid_q[LAT-1] & ~flush & ~inv_mask[LAT-1];
   assign ret_addr = addr_q[LAT-1];

endmodule

// File: rtl/fc_seqq.sv
`timescale 1ns/1ps
module fc_seqq #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 3,
   parameter int DEPTH  = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [OFS_W-1:0]  push_ofs,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [OFS_W-1:0]  head_ofs,
   output logic              empty,
   output logic              full
);

   logic [ADDR_W-1:0] ent_addr [DEPTH];
   logic [OFS_W-1:0]  ent_ofs  [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  count;
   logic              do_push, do_pop;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         if (do_push) wr_ptr <= bump(wr_ptr);
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (rst_n && !clear && do_push) begin
         ent_addr[wr_ptr] <= push_addr;
         ent_ofs[wr_ptr]  <= push_ofs;
      end
   end

   assign head_addr = ent_addr[rd_ptr];
   assign head_ofs  = ent_ofs[rd_ptr];

endmodule

// File: rtl/fetch_ctl.sv
`timescale 1ns/1ps
module fetch_ctl
   import fetch_ctl_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter int              LINE_LG2  = 5,
   parameter int              OFS_W     = 3,
   parameter int              LAT       = 2,
   parameter int              NBUF      = 6,
   parameter int              SQ_DEPTH  = 4,
   parameter logic [ADDR_W-1:0] RESET_VEC = 'h100,
   localparam int             FREE_W    = $clog2(NBUF + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cache_ready,
   input  logic [FREE_W-1:0]     buf_free,
   input  logic                  pbr_req,
   input  logic [ADDR_W-1:0]     pbr_tgt,
   input  logic                  mp_valid,
   input  logic                  mp_pred_taken,
   input  logic [ADDR_W-1:0]     mp_tgt,
   input  logic                  exc_req,
   input  logic [ADDR_W-1:0]     exc_vec,
   input  logic [LAT-1:0]        inv_mask,
   input  logic [LAT-1:0]        onpath_set,
   input  logic                  pbd_valid,
   input  logic [ADDR_W-1:0]     pbd_addr,
   input  logic [OFS_W-1:0]      pbd_ofs,
   input  logic                  pb_retire,
   output logic                  req_valid,
   output logic [ADDR_W-1:0]     req_addr,
   output logic [OFS_W-1:0]      req_ofs,
   output logic                  rsp_keep,
   output logic [ADDR_W-1:0]     rsp_addr,
   output logic [LAT-1:0]        ot_busy,
   output logic [LAT-1:0]        ot_valid,
   output logic [LAT-1:0]        ot_onpath,
   output logic [LAT*ADDR_W-1:0] ot_addr
);

   localparam int                CNT_W     = $clog2(LAT + 1);
   localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(1) << LINE_LG2;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("fetch_ctl: LAT must be at least 1");
      end
      if (SQ_DEPTH < 2) begin : g_bad_depth
         $error("fetch_ctl: SQ_DEPTH must be at least 2");
      end
      if (LINE_LG2 < 1 || LINE_LG2 >= ADDR_W) begin : g_bad_line
         $error("fetch_ctl: LINE_LG2 out of range");
      end
   endgenerate

   function automatic logic [ADDR_W-1:0] to_line(input logic [ADDR_W-1:0] a);
      return {a[ADDR_W-1:LINE_LG2], {LINE_LG2{1'b0}}};
   endfunction

   logic [FC_FLAG_W-1:0] held_flags;
   logic [ADDR_W-1:0]    held_addr, seq_ptr;
   logic [OFS_W-1:0]     held_ofs;

   logic                 flush, issue, seq_room, sq_empty, sq_full;
   logic [ADDR_W-1:0]    iss_addr, nxt_addr, sq_addr;
   logic [OFS_W-1:0]     iss_ofs, nxt_ofs, sq_ofs;
   fc_rank_e             nxt_rank;
   logic [CNT_W-1:0]     live_cnt;
   logic [LAT-1:0][ADDR_W-1:0] slot_addr;

   assign flush    = mp_valid | exc_req;
   assign seq_room = (int'(buf_free) > int'(live_cnt));

   fc_arbiter #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_arb (
      .cache_ready   (cache_ready),
      .held_rank     (rank_of(held_flags)),
      .held_addr     (held_addr),
      .held_ofs      (held_ofs),
      .exc_req       (exc_req),
      .exc_addr      (to_line(exc_vec)),
      .mp_valid      (mp_valid),
      .mp_pred_taken (mp_pred_taken),
      .mp_addr       (to_line(mp_tgt)),
      .rec_addr      (sq_addr),
      .rec_ofs       (sq_ofs),
      .pbr_req       (pbr_req),
      .pbr_addr      (to_line(pbr_tgt)),
      .seq_room      (seq_room),
      .seq_addr      (seq_ptr),
      .issue         (issue),
      .iss_addr      (iss_addr),
      .iss_ofs       (iss_ofs),
      .nxt_rank      (nxt_rank),
      .nxt_addr      (nxt_addr),
      .nxt_ofs       (nxt_ofs)
   );

   fc_otable #(.ADDR_W(ADDR_W), .LAT(LAT)) u_tab (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .iss_addr   (iss_addr),
      .flush      (flush),
      .inv_mask   (inv_mask),
      .onpath_set (onpath_set),
      .busy       (ot_busy),
      .valid      (ot_valid),
      .onpath     (ot_onpath),
      .addr       (slot_addr),
      .ret_keep   (rsp_keep),
      .ret_addr   (rsp_addr),
      .live_cnt   (live_cnt)
   );

   fc_seqq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DEPTH(SQ_DEPTH)) u_sq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (flush),
      .push      (pbd_valid & ~flush),
      .push_addr (to_line(pbd_addr)),
      .push_ofs  (pbd_ofs),
      .pop       (pb_retire & ~flush),
      .head_addr (sq_addr),
      .head_ofs  (sq_ofs),
      .empty     (sq_empty),
      .full      (sq_full)
   );

   // next-fetch register and sequential pointer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_flags <= flags_of(RK_EXC);
         held_addr  <= to_line(RESET_VEC);
         held_ofs   <= '0;
         seq_ptr    <= to_line(RESET_VEC);
      end else begin
         held_flags <= flags_of(nxt_rank);
         held_addr  <= nxt_addr;
         held_ofs   <= nxt_ofs;
         if (issue) seq_ptr <= iss_addr + LINE_STEP;
      end
   end

   generate
      for (genvar g = 0; g < LAT; g++) begin : g_tag
         assign ot_addr[g*ADDR_W +: ADDR_W] = slot_addr[g];
      end
   endgenerate

   assign req_valid = issue;
   assign req_addr  = iss_addr;
   assign req_ofs   = iss_ofs;

endmodule

// File: rtl/fetch_ctl_chk.sv
`timescale 1ns/1ps
module fetch_ctl_chk #(
   parameter int ADDR_W   = 32,
   parameter int LINE_LG2 = 5,
   parameter int LAT      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cache_ready,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              exc_req,
   input logic [ADDR_W-1:0] exc_vec,
   input logic              mp_valid,
   input logic              rsp_keep,
   input logic [2:0]        held_flags,
   input logic              sq_full,
   input logic              pbd_valid,
   input logic              pb_retire,
   input logic [LAT-1:0]    ot_busy
);

   AST_IDLE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !cache_ready |-> !req_valid); // R2

   AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(held_flags)); // R4

   AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && cache_ready |-> req_valid &&
      req_addr[ADDR_W-1:LINE_LG2] == exc_vec[ADDR_W-1:LINE_LG2]); // R3

   AST_EXC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && !cache_ready |=> held_flags[2]); // R4

   AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      mp_valid && (LAT > 1) |=> !rsp_keep); // R8

   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_addr[LINE_LG2-1:0] == '0); // R11

   AST_ISSUE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ot_busy[0]); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pbd_valid && sq_full |-> pb_retire || mp_valid || exc_req); // R10

endmodule

bind fetch_ctl fetch_ctl_chk #(.ADDR_W(ADDR_W), .LINE_LG2(LINE_LG2), .LAT(LAT)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cache_ready (cache_ready),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .exc_req     (exc_req),
   .exc_vec     (exc_vec),
   .mp_valid    (mp_valid),
   .rsp_keep    (rsp_keep),
   .held_flags  (held_flags),
   .sq_full     (sq_full),
   .pbd_valid   (pbd_valid),
   .pb_retire   (pb_retire),
   .ot_busy     (ot_busy)
);

// File: tb/test_fetch_ctl.sv
`timescale 1ns/1ps
module test_fetch_ctl;

   localparam int          AW   = 32;
   localparam int          LAT  = 2;
   localparam int          SQD  = 4;
   localparam logic [31:0] RVEC = 32'h100;

   logic          clk = 1'b0, rst_n = 1'b0, cache_ready = 1'b0;
   logic [2:0]    buf_free = '0;
   logic          pbr_req = 0, mp_valid = 0, mp_pred_taken = 0, exc_req = 0;
   logic [31:0]   pbr_tgt = '0, mp_tgt = '0, exc_vec = '0, pbd_addr = '0;
   logic [LAT-1:0] inv_mask = '0, onpath_set = '0;
   logic          pbd_valid = 0, pb_retire = 0;
   logic [2:0]    pbd_ofs = '0;
   logic          req_valid, rsp_keep;
   logic [31:0]   req_addr, rsp_addr;
   logic [2:0]    req_ofs;
   logic [LAT-1:0] ot_busy, ot_valid, ot_onpath;
   logic [LAT*AW-1:0] ot_addr;

   int errors = 0, checks = 0;
   bit done = 0;

   fetch_ctl #(.LAT(LAT), .SQ_DEPTH(SQD), .RESET_VEC(RVEC)) i_fetch_ctl (
      .clk(clk), .rst_n(rst_n), .cache_ready(cache_ready), .buf_free(buf_free),
      .pbr_req(pbr_req), .pbr_tgt(pbr_tgt), .mp_valid(mp_valid),
      .mp_pred_taken(mp_pred_taken), .mp_tgt(mp_tgt), .exc_req(exc_req),
      .exc_vec(exc_vec), .inv_mask(inv_mask), .onpath_set(onpath_set),
      .pbd_valid(pbd_valid), .pbd_addr(pbd_addr), .pbd_ofs(pbd_ofs),
      .pb_retire(pb_retire), .req_valid(req_valid), .req_addr(req_addr),
      .req_ofs(req_ofs), .rsp_keep(rsp_keep), .rsp_addr(rsp_addr),
      .ot_busy(ot_busy), .ot_valid(ot_valid), .ot_onpath(ot_onpath),
      .ot_addr(ot_addr)
   );

   always #2 clk = ~clk;   // 250 MHz

   // reference model state
   bit          m_busy[LAT], m_val[LAT], m_on[LAT];
   logic [31:0] m_addr[LAT];
   int          m_hr;
   logic [31:0] m_ha, m_seq;
   logic [2:0]  m_ho;
   logic [31:0] q_addr[$];
   logic [2:0]  q_ofs[$];

   function automatic logic [31:0] al(input logic [31:0] a);
      return a & ~32'h1f;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < LAT; i++) begin
         m_busy[i] = 0; m_val[i] = 0; m_on[i] = 0; m_addr[i] = '0;
      end
      m_hr = 3; m_ha = al(RVEC); m_ho = '0; m_seq = al(RVEC);
      q_addr.delete(); q_ofs.delete();
   endtask

   // compare at mid-cycle, then advance model as the next edge will
   task automatic sample(input string tag);
      int ir, cr, cnt;
      logic [31:0] ia, ca, xa;
      logic [2:0]  io, co, xo;
      bit iss, fl, kp;
      #1;
      ir = 0; ia = '0; io = '0;
      if (exc_req) begin ir = 3; ia = al(exc_vec); end
      else if (mp_valid) begin
         ir = 2;
         if (mp_pred_taken) begin ia = q_addr[0]; io = q_ofs[0]; end
         else ia = al(mp_tgt);
      end else if (pbr_req) begin ir = 1; ia = al(pbr_tgt); end
      if (ir != 0 && ir >= m_hr) begin cr = ir; ca = ia; co = io; end
      else begin cr = m_hr; ca = m_ha; co = m_ho; end
      cnt = 0;
      for (int i = 0; i < LAT; i++) if (m_busy[i] && m_val[i]) cnt++;
      iss = 0; xa = '0; xo = '0;
      if (cr != 0) begin
         if (cache_ready) begin iss = 1; xa = ca; xo = co; m_hr = 0; end
         else begin m_hr = cr; m_ha = ca; m_ho = co; end
      end else if (cache_ready && int'(buf_free) > cnt) begin
         iss = 1; xa = m_seq; xo = '0;
      end
      fl = exc_req | mp_valid;
      kp = m_busy[LAT-1] && m_val[LAT-1] && !fl && !inv_mask[LAT-1];

      chk({tag, " req_valid"}, 64'(req_valid), 64'(iss));
      if (iss) begin
         chk({tag, " req_addr"}, 64'(req_addr), 64'(xa));
         chk({tag, " req_ofs"}, 64'(req_ofs), 64'(xo));
         chk("R11 line alignment", 64'(req_addr[4:0]), 64'd0);
      end
      chk("R8 rsp_keep", 64'(rsp_keep), 64'(kp));
      if (kp) chk("R7 rsp_addr", 64'(rsp_addr), 64'(m_addr[LAT-1]));
      for (int i = 0; i < LAT; i++) begin
         chk("R7 slot busy", 64'(ot_busy[i]), 64'(m_busy[i]));
         if (m_busy[i]) begin
            chk("R9 slot valid", 64'(ot_valid[i]), 64'(m_val[i]));
            chk("R9 slot onpath", 64'(ot_onpath[i]), 64'(m_on[i]));
            chk("R7 slot addr", 64'(ot_addr[i*AW +: AW]), 64'(m_addr[i]));
         end
      end

      for (int i = LAT - 1; i >= 1; i--) begin
         m_busy[i] = m_busy[i-1];
         m_val[i]  = m_val[i-1] && !(fl || inv_mask[i-1]);
         m_on[i]   = m_on[i-1] || onpath_set[i-1];
         m_addr[i] = m_addr[i-1];
      end
      m_busy[0] = iss; m_val[0] = iss; m_on[0] = 0;
      if (iss) begin m_addr[0] = xa; m_seq = xa + 32; end
      if (fl) begin q_addr.delete(); q_ofs.delete(); end
      else begin
         if (pb_retire && q_addr.size() > 0) begin
            void'(q_addr.pop_front()); void'(q_ofs.pop_front());
         end
         if (pbd_valid) begin q_addr.push_back(al(pbd_addr)); q_ofs.push_back(pbd_ofs); end
      end
   endtask

   task automatic adv();
      @(negedge clk);
      pbr_req = 0; mp_valid = 0; mp_pred_taken = 0; exc_req = 0;
      inv_mask = '0; onpath_set = '0; pbd_valid = 0; pb_retire = 0;
   endtask

   task automatic step(input string tag, input int n);
      for (int k = 0; k < n; k++) begin sample(tag); adv(); end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset busy", 64'(ot_busy), 64'd0);
      chk("R1 reset keep", 64'(rsp_keep), 64'd0);
      @(negedge clk);
      rst_n = 1; cache_ready = 1; buf_free = 0;
      model_reset();

      // R1: first fetch is the reset vector
      sample("R1"); chk("R1 first addr", 64'(req_addr), 64'(RVEC)); adv();
      sample("R5"); chk("R5 no room", 64'(req_valid), 64'd0); adv();

      // R5/R6: refill room boundary and pointer stepping
      buf_free = 2;
      sample("R5"); chk("R6 seq addr", 64'(req_addr), 64'h120); adv();
      sample("R5"); adv();
      sample("R5"); chk("R5 room equals in-flight", 64'(req_valid), 64'd0); adv();
      buf_free = 3; step("R5", 2);
      buf_free = 6; step("R5", 3);

      // R2/R4: hold while busy, keep the strongest
      cache_ready = 0;
      pbr_req = 1; pbr_tgt = 32'h1000;
      sample("R2"); chk("R2 busy no request", 64'(req_valid), 64'd0); adv();
      mp_valid = 1; mp_tgt = 32'h2004; step("R4", 1);
      pbr_req = 1; pbr_tgt = 32'h3000; step("R4", 1);
      cache_ready = 1;
      sample("R4"); chk("R4 held mispredict issued", 64'(req_addr), 64'h2000); adv();
      sample("R6"); chk("R6 refill after redirect", 64'(req_addr), 64'h2020); adv();

      // R3: same-cycle priority
      exc_req = 1; exc_vec = 32'h400; mp_valid = 1; mp_tgt = 32'h5000; pbr_req = 1; pbr_tgt = 32'h6000;
      sample("R3"); chk("R3 exception wins", 64'(req_addr), 64'h400); adv();
      mp_valid = 1; mp_tgt = 32'h5000; pbr_req = 1; pbr_tgt = 32'h6000;
      sample("R3"); chk("R3 mispredict over PBR", 64'(req_addr), 64'h5000); adv();
      pbr_req = 1; pbr_tgt = 32'h6040;
      sample("R3"); chk("R3 PBR over refill", 64'(req_addr), 64'h6040); adv();

      // R9: tracker masks
      step("R9", 2);
      inv_mask = 2'b10; onpath_set = 2'b01;
      sample("R9"); chk("R9 returning slot dropped", 64'(rsp_keep), 64'd0); adv();
      step("R9", 2);

      // R10: sequential-target queue recovery
      pbd_valid = 1; pbd_addr = 32'h7000; pbd_ofs = 3'd5; step("R10", 1);
      pbd_valid = 1; pbd_addr = 32'h7100; pbd_ofs = 3'd3; step("R10", 1);
      pb_retire = 1; step("R10", 1);
      mp_valid = 1; mp_pred_taken = 1;
      sample("R10"); chk("R10 recovery addr", 64'(req_addr), 64'h7100);
      chk("R10 recovery ofs", 64'(req_ofs), 64'd3); adv();
      sample("R10"); chk("R10 ofs zero after", 64'(req_ofs), 64'd0); adv();

      // R8: flush hits returning fetch
      step("R8", 2);
      mp_valid = 1; mp_tgt = 32'h8000;
      sample("R8"); chk("R8 same-cycle drop", 64'(rsp_keep), 64'd0); adv();
      step("R8", 3);

      // random collisions
      for (int c = 0; c < 4000; c++) begin
         cache_ready = ($urandom % 4) != 0;
         buf_free    = 3'($urandom % 7);
         pbr_req     = ($urandom % 8) == 0;  pbr_tgt = $urandom;
         mp_valid    = ($urandom % 14) == 0; mp_tgt = $urandom;
         mp_pred_taken = mp_valid && q_addr.size() > 0 && ($urandom % 2);
         exc_req     = ($urandom % 40) == 0; exc_vec = $urandom;
         if (($urandom % 5) == 0) inv_mask = LAT'($urandom);
         if (($urandom % 5) == 0) onpath_set = LAT'($urandom);
         pb_retire   = ($urandom % 6) == 0;
         pbd_valid   = (q_addr.size() < SQD) && (($urandom % 5) == 0);
         pbd_addr    = $urandom; pbd_ofs = 3'($urandom);
         step("R4", 1);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule